// File: doc/BRIEF.md
# Register Write-Lock Hazard Detector

This block finds data hazards for an in-order pipeline with no forwarding paths. When an instruction leaves operand fetch and will write a general-purpose register, its destination goes into a short shift queue as a one-hot mask. The queue has one slot for each stage between operand fetch and retirement. All slots are ORed into a lock mask. An instruction waiting in operand fetch is held with a bubble while any register it reads is locked. The lock clears as soon as the writer falls off the end of the queue.

Register x0 always reads as zero, so it never needs a lock. Its bit in each mask is used instead to record a pending memory store. A load that arrives while that flag is set is stalled, so memory read-after-write ordering is kept. The oldest slot in the queue also supplies the one-hot register-file write enable: it is gated by the single write-enable bit from the retire stage.

Top module: `reg_lock_queue`

## Requirements
- R1: While reset is high, every queue slot is cleared, so on the cycle after reset both `lock_mask` and `rf_we` are zero.
- R2: An accepted instruction (`iss_valid` high, `bubble` low) with `rd_wr` high and `rd_idx` not zero sets bit `rd_idx` of `lock_mask` for exactly the two cycles that follow its issue edge. The bit is clear in the third cycle.
- R3: `lock_mask` is the OR of all queue slots, so two back-to-back writers to different registers are both visible in the mask.
- R4: `bubble` is high when `iss_valid` is high and a non-zero `rs1_idx` or `rs2_idx` selects a set bit of `lock_mask`. It stays high until that bit clears.
- R5: A source index of 0 never causes a stall.
- R6: An accepted instruction with `mem_wr` high sets bit 0 of `lock_mask` for two cycles. While that bit is set, an instruction with `mem_rd` high is stalled, and one with `mem_rd` low is not stalled by it.
- R7: A writer with `rd_idx` equal to 0, or with `rd_wr` low, adds no register lock.
- R8: On a cycle with `bubble` high or `iss_valid` low, an all-zero slot is pushed. A stalled writer's destination is therefore not locked until the writer is actually accepted.
- R9: `rf_we` is the oldest queue slot ANDed with `ret_we`, with bit 0 always forced to 0. It shows bit `rd_idx` in the second cycle after the writer's issue edge.
- R10: When `ret_we` is low, `rf_we` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction is waiting in operand fetch |
| rs1_idx | input | 5 | First source register index (0 = none) |
| rs2_idx | input | 5 | Second source register index (0 = none) |
| rd_idx | input | 5 | Destination register index |
| rd_wr | input | 1 | Instruction will write `rd_idx` |
| mem_wr | input | 1 | Instruction is a memory store |
| mem_rd | input | 1 | Instruction is a memory load |
| ret_we | input | 1 | Write enable from the retire stage |
| bubble | output | 1 | Stall the waiting instruction |
| lock_mask | output | 32 | OR of all queue slots; bit 0 marks a pending store |
| rf_we | output | 32 | One-hot register-file write enable |

## Verification
The assertions assume that the upstream stage holds a stalled instruction's fields steady and that `ret_we` only matters when the head slot carries a real writer. The bench drives a stalled instruction unchanged until `bubble` drops. It raises `ret_we` only in the cycle a checked writer reaches the head, except in the case that tests gating with `ret_we` low. Source indices are either 0 or exactly the register under test, so every stall the bench expects comes from a single, known lock.

// File: rtl/rlq_pkg.sv
package rlq_pkg;
    localparam int unsigned NREG = 32;
    localparam int unsigned IDXW = $clog2(NREG);
    localparam int unsigned MEM_FLAG = 0;

    typedef logic [NREG-1:0] regmask_t;
    typedef logic [IDXW-1:0] regidx_t;

    typedef struct packed {
        logic    valid;
        regidx_t rs1;
        regidx_t rs2;
        regidx_t rd;
        logic    rd_wr;
        logic    mem_wr;
        logic    mem_rd;
    } issue_t;

    function automatic regmask_t onehot(input regidx_t idx);
        regmask_t m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/rlq_entry_gen.sv
module rlq_entry_gen
    import rlq_pkg::*;
(
    input  issue_t   iss,
    input  logic     stall,
    output regmask_t ent
);
    regmask_t dst_bits;
    regmask_t mem_bits;

    always_comb begin
        dst_bits = '0;
        mem_bits = '0;
        if (iss.rd_wr && iss.rd != '0)
            dst_bits = onehot(iss.rd);
        if (iss.mem_wr)
            mem_bits[MEM_FLAG] = 1'b1;
        if (iss.valid && !stall)
            ent = dst_bits | mem_bits;
        else
            ent = '0;
    end
endmodule

// File: rtl/rlq_shift.sv
module rlq_shift
    import rlq_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  regmask_t push,
    output regmask_t tail,
    output regmask_t head,
    output regmask_t ored
);
    regmask_t slot [DEPTH];
    regmask_t acc  [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)
            slot[0] <= '0;
        else
            slot[0] <= push;
    end

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    slot[i] <= '0;
                else
                    slot[i] <= slot[i-1];
            end
        end
    endgenerate

    assign acc[0] = slot[0];
    generate
        for (genvar j = 1; j < DEPTH; j++) begin : g_or
            assign acc[j] = acc[j-1] | slot[j];
        end
    endgenerate

    assign tail = slot[0];
    assign head = slot[DEPTH-1];
    assign ored = acc[DEPTH-1];
endmodule

// File: rtl/rlq_hazard.sv
module rlq_hazard
    import rlq_pkg::*;
(
    input  issue_t   iss,
    input  regmask_t mask,
    output logic     stall
);
    logic hit1, hit2, hitm;

    always_comb begin
        hit1  = (iss.rs1 != '0) && mask[iss.rs1];
        hit2  = (iss.rs2 != '0) && mask[iss.rs2];
        hitm  = iss.mem_rd && mask[MEM_FLAG];
        stall = iss.valid && (hit1 || hit2 || hitm);
    end
endmodule

// File: rtl/reg_lock_queue.sv
module reg_lock_queue
    import rlq_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_valid,
    input  logic [IDXW-1:0] rs1_idx,
    input  logic [IDXW-1:0] rs2_idx,
    input  logic [IDXW-1:0] rd_idx,
    input  logic            rd_wr,
    input  logic            mem_wr,
    input  logic            mem_rd,
    input  logic            ret_we,
    output logic            bubble,
    output logic [NREG-1:0] lock_mask,
    output logic [NREG-1:0] rf_we
);
    issue_t   iss;
    regmask_t push_ent;
    regmask_t tail_ent;
    regmask_t head_ent;
    regmask_t or_mask;
    logic     stall;

    assign iss = '{valid: iss_valid, rs1: rs1_idx, rs2: rs2_idx, rd: rd_idx,
                   rd_wr: rd_wr, mem_wr: mem_wr, mem_rd: mem_rd};

    rlq_hazard u_haz (
        .iss   (iss),
        .mask  (or_mask),
        .stall (stall)
    );

    rlq_entry_gen u_ent (
        .iss   (iss),
        .stall (stall),
        .ent   (push_ent)
    );

    rlq_shift #(.DEPTH(DEPTH)) u_q (
        .clk  (clk),
        .rst  (rst),
        .push (push_ent),
        .tail (tail_ent),
        .head (head_ent),
        .ored (or_mask)
    );

    always_comb begin
        rf_we = head_ent & {NREG{ret_we}};
        rf_we[MEM_FLAG] = 1'b0;
    end

    assign bubble    = stall;
    assign lock_mask = or_mask;
endmodule

// File: rtl/reg_lock_queue_chk.sv
module reg_lock_queue_chk
    import rlq_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            iss_valid,
    input logic [IDXW-1:0] rs1_idx,
    input logic [IDXW-1:0] rs2_idx,
    input logic [IDXW-1:0] rd_idx,
    input logic            rd_wr,
    input logic            mem_wr,
    input logic            mem_rd,
    input logic            ret_we,
    input logic            bubble,
    input logic [NREG-1:0] lock_mask,
    input logic [NREG-1:0] rf_we,
    input logic [NREG-1:0] tail_ent
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (lock_mask == '0 && rf_we == '0));

    a_r2_lock_set: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !bubble && rd_wr && rd_idx != '0) |=> lock_mask[$past(rd_idx)]);

    a_r3_lock_bound: assert property (@(posedge clk) disable iff (rst)
        $countones(lock_mask[NREG-1:1]) <= DEPTH);

    a_r5_x0_free: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && rs1_idx == '0 && rs2_idx == '0 && !mem_rd) |-> !bubble);

    a_r6_mem_flag: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !bubble && mem_wr) |=> lock_mask[0]);

    a_r8_zero_push: assert property (@(posedge clk) disable iff (rst)
        (bubble || !iss_valid) |=> tail_ent == '0);

    a_r9_no_x0_write: assert property (@(posedge clk) disable iff (rst)
        rf_we[0] == 1'b0);

    a_r10_gated: assert property (@(posedge clk) disable iff (rst)
        !ret_we |-> rf_we == '0);
endmodule

bind reg_lock_queue reg_lock_queue_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_reg_lock_queue.sv
module sim_reg_lock_queue;
    logic        clk = 1'b0;
    logic        rst;
    logic        iss_valid;
    logic [4:0]  rs1_idx, rs2_idx, rd_idx;
    logic        rd_wr, mem_wr, mem_rd, ret_we;
    logic        bubble;
    logic [31:0] lock_mask, rf_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    reg_lock_queue u0 (
        .clk(clk), .rst(rst), .iss_valid(iss_valid),
        .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx),
        .rd_wr(rd_wr), .mem_wr(mem_wr), .mem_rd(mem_rd), .ret_we(ret_we),
        .bubble(bubble), .lock_mask(lock_mask), .rf_we(rf_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic v, input int s1, input int s2, input int d,
                         input logic w, input logic mw, input logic mr, input logic rw);
        iss_valid = v;
        rs1_idx = 5'(s1);
        rs2_idx = 5'(s2);
        rd_idx = 5'(d);
        rd_wr = w;
        mem_wr = mw;
        mem_rd = mr;
        ret_we = rw;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        rst = 1'b1;
        idle();
        tick(); tick();
        rst = 1'b0;
        // R1: queue empty after reset
        drive(1'b1, 3, 4, 0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R1 mask", lock_mask, 32'h0);
        chk("R1 rf_we", rf_we, 32'h0);
        chk("R1 bubble", {31'b0, bubble}, 32'h0);
        idle();

        // R2 R4 R9: sweep every destination register
        for (int r = 1; r < 32; r++) begin
            tick();
            drive(1'b1, 0, 0, r, 1'b1, 1'b0, 1'b0, 1'b0);
            chk("R5 writer not stalled", {31'b0, bubble}, 32'h0);
            tick();
            if (r % 2 == 1) drive(1'b1, r, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
            else            drive(1'b1, 0, r, 0, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R2 lock first cycle", lock_mask, 32'h1 << r);
            chk("R4 bubble first cycle", {31'b0, bubble}, 32'h1);
            tick();
            ret_we = 1'b1; #1;
            chk("R2 lock second cycle", lock_mask, 32'h1 << r);
            chk("R4 bubble held", {31'b0, bubble}, 32'h1);
            chk("R9 write enable", rf_we, 32'h1 << r);
            tick();
            ret_we = 1'b0; #1;
            chk("R2 lock cleared", lock_mask, 32'h0);
            chk("R4 bubble released", {31'b0, bubble}, 32'h0);
            idle();
        end

        // R7: rd of 0 and rd_wr low lock nothing
        tick();
        drive(1'b1, 0, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        drive(1'b1, 0, 0, 9, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 rd zero no lock", lock_mask, 32'h0);
        tick();
        idle();
        chk("R7 rd_wr low no lock", lock_mask, 32'h0);

        // R3: two back-to-back writers
        tick();
        drive(1'b1, 0, 0, 1, 1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        drive(1'b1, 0, 0, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 first writer not stalled", {31'b0, bubble}, 32'h0);
        tick();
        idle();
        chk("R3 OR of slots", lock_mask, 32'h6);
        tick(); tick();

        // R6: store then load, store then non-load
        drive(1'b1, 0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        tick();
        drive(1'b1, 0, 0, 7, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R6 store flag", lock_mask, 32'h1);
        chk("R6 load stalled", {31'b0, bubble}, 32'h1);
        tick();
        ret_we = 1'b1; #1;
        chk("R6 load still stalled", {31'b0, bubble}, 32'h1);
        chk("R9 bit0 never written", rf_we, 32'h0);
        tick();
        ret_we = 1'b0; #1;
        chk("R6 load released", {31'b0, bubble}, 32'h0);
        tick();
        drive(1'b1, 0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        tick();
        drive(1'b1, 0, 0, 8, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R6 non-load not stalled", {31'b0, bubble}, 32'h0);
        chk("R5 x0 sources with flag set", lock_mask, 32'h1 | (32'h1 << 7));
        tick();
        idle();
        tick(); tick();

        // R8: stalled writer pushes a zero slot
        drive(1'b1, 0, 0, 3, 1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        drive(1'b1, 3, 0, 4, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 stalled", {31'b0, bubble}, 32'h1);
        tick();
        chk("R8 stalled writer not locked", lock_mask, 32'h8);
        tick();
        chk("R8 writer accepted", {31'b0, bubble}, 32'h0);
        tick();
        idle();
        chk("R8 lock after accept", lock_mask, 32'h10);

        // R10: retire enable low gates the head
        tick();
        drive(1'b1, 0, 0, 12, 1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        idle();
        tick();
        chk("R10 gated write enable", rf_we, 32'h0);
        chk("R10 head still locked", lock_mask, 32'h1000);

        // R1: reset mid-flight clears the queue
        drive(1'b1, 0, 0, 20, 1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        rst = 1'b1;
        idle();
        tick();
        rst = 1'b0;
        #1;
        chk("R1 reset clears queue", lock_mask, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule